// File: doc/BRIEF.md
# Delayed Bus Parity Generator and Checker

This block computes and checks the parity bit of a 32-bit multiplexed address/data bus that also carries a 4-bit command/byte-enable field. Parity is even over all 36 bits, so the 37 bits including the parity bit always hold an even number of ones. The parity bit always appears one clock after the bits it covers.

From the local role (master or target), the bus phase (address or data) and the transfer direction (read or write), the block decides each cycle whether the local side is driving the bus. When it is, the block drives parity and its output enable in the next clock. When the far side is driving and an address phase or a completed data transfer takes place, the block compares the parity received one clock later against its own calculation. A mismatch produces a one-clock address-error or data-error pulse.

All control inputs are active-high views of the bus state, decoded elsewhere. `addr_phase` marks the single address cycle of a transaction. `txn_active` marks the data phases that follow it.

Top module: `bus_parity_unit`

## Requirements
- R1: In the cycle after any cycle N with reset low, `parity_out` equals the XOR of `bus_data` and `bus_cmd_be` from cycle N. The 37 bits then carry an even count of ones.
- R2: When `addr_phase` and `role_master` are both high in cycle N, `parity_oe` is high in cycle N+1.
- R3: When `txn_active` is high, `addr_phase` is low, `role_master` is high and `dir_write` is high in cycle N, `parity_oe` is high in cycle N+1. This covers master write data phases, ready or waiting.
- R4: When `txn_active` is high, `addr_phase` is low, `role_master` is low and `dir_write` is low in cycle N, `parity_oe` is high in cycle N+1. This covers target read data phases.
- R5: In every other cycle N, `parity_oe` is low in cycle N+1. This includes a target in an address phase, a master reading, a target being written, and an idle bus. `addr_phase` takes precedence over `txn_active`.
- R6: Suppose `addr_phase` is high and `role_master` is low in cycle N. Then `addr_err` is high for the single cycle N+2 exactly when `parity_in` in cycle N+1 differs from the XOR of the 36 bits of cycle N.
- R7: Suppose cycle N is a completed data transfer driven by the far side. That means `txn_active`, `init_ready` and `targ_ready` are high, `addr_phase` is low, and `role_master` differs from `dir_write`. Then `data_err` is high for cycle N+2 exactly when `parity_in` in cycle N+1 differs from the XOR of the 36 bits of cycle N.
- R8: No error is raised in cycle N+2 when cycle N was neither of the R6 or R7 cases. This covers wait states (either ready low), locally driven phases and idle cycles, whatever `parity_in` is. The two error outputs are never high together.
- R9: While `rst` is high, and in the cycle after a reset edge, `parity_out`, `parity_oe`, `addr_err` and `data_err` are all low. No check is made on bits captured under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 32 | Address/data bits as seen on the bus |
| bus_cmd_be | input | 4 | Command/byte-enable bits as seen on the bus |
| addr_phase | input | 1 | Address cycle of a transaction |
| txn_active | input | 1 | Data phases of a transaction in progress |
| role_master | input | 1 | Local side is the initiator of the transaction |
| dir_write | input | 1 | Transaction writes from master to target |
| init_ready | input | 1 | Initiator ready asserted this cycle |
| targ_ready | input | 1 | Target ready asserted this cycle |
| parity_in | input | 1 | Parity bit as seen on the bus |
| parity_out | output | 1 | Registered parity of the previous cycle's 36 bits |
| parity_oe | output | 1 | Drive enable for parity_out |
| addr_err | output | 1 | One-clock address-parity mismatch pulse |
| data_err | output | 1 | One-clock data-parity mismatch pulse |

## Verification
Every register in this block shows up at the ports within two clocks. A faulty parity register shows as a wrong `parity_out` in the very next cycle. A wrong drive decision shows as a wrong `parity_oe` in that same cycle. A wrong stored check kind, or a bad compare, shows on `addr_err` or `data_err` two cycles after the covered bits. Each clock, the bench compares all four outputs against a reference model that keeps a two-deep history of the inputs. Directed phases run alongside random traffic that includes deliberately corrupted parity.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  typedef enum logic [1:0] {
    CHK_NONE = 2'd0,
    CHK_ADDR = 2'd1,
    CHK_DATA = 2'd2
  } chk_kind_e;

endpackage

// File: rtl/bpu_xor_tree.sv
// Balanced XOR reduction, padded with zeros to a power of two.
module bpu_xor_tree #(
  parameter int W = 36
) (
  input  logic [W-1:0] vec,
  output logic         odd
);
  localparam int LV = (W > 1) ? $clog2(W) : 0;
  localparam int P  = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    logic [(P >> l)-1:0] node;
    if (l == 0) begin : g_leaf
      assign node = P'(vec);
    end else begin : g_inner
      for (genvar i = 0; i < (P >> l); i++) begin : g_x
        assign node[i] = g_lv[l-1].node[2*i] ^ g_lv[l-1].node[2*i+1];
      end
    end
  end

  assign odd = g_lv[LV].node[0];
endmodule

// File: rtl/bpu_role_decode.sv
// Decides who owns the bus bits this cycle and whether a check is due.
module bpu_role_decode
  import bpu_pkg::*;
(
  input  logic      addr_phase,
  input  logic      txn_active,
  input  logic      role_master,
  input  logic      dir_write,
  input  logic      init_ready,
  input  logic      targ_ready,
  output logic      local_drive,
  output chk_kind_e chk_kind
);
  logic in_data;
  logic local_owns_data;
  logic xfer_done;

  always_comb begin
    in_data         = txn_active && !addr_phase;
    // master owns data on writes, target on reads
    local_owns_data = (role_master == dir_write);
    xfer_done       = in_data && init_ready && targ_ready;

    local_drive = (addr_phase && role_master) || (in_data && local_owns_data);

    if (addr_phase && !role_master)
      chk_kind = CHK_ADDR;
    else if (xfer_done && !local_owns_data)
      chk_kind = CHK_DATA;
    else
      chk_kind = CHK_NONE;
  end
endmodule

// File: rtl/bpu_par_drive.sv
// Parity and enable registers: both lag the covered bits by one clock.
module bpu_par_drive (
  input  logic clk,
  input  logic rst,
  input  logic odd_now,
  input  logic local_drive,
  output logic par_q,
  output logic oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= odd_now;
      oe_q  <= local_drive;
    end
  end
endmodule

// File: rtl/bpu_par_check.sv
// Holds the pending check kind for one clock, then compares the stored
// parity with the received bit and registers a one-clock error pulse.
module bpu_par_check
  import bpu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  chk_kind_e chk_kind,
  input  logic      calc_par,
  input  logic      par_rx,
  output logic      addr_err_q,
  output logic      data_err_q
);
  chk_kind_e kind_q;
  logic      mismatch;

  assign mismatch = calc_par ^ par_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q     <= CHK_NONE;
      addr_err_q <= 1'b0;
      data_err_q <= 1'b0;
    end else begin
      kind_q     <= chk_kind;
      addr_err_q <= (kind_q == CHK_ADDR) && mismatch;
      data_err_q <= (kind_q == CHK_DATA) && mismatch;
    end
  end
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [CBE_W-1:0]  bus_cmd_be,
  input  logic              addr_phase,
  input  logic              txn_active,
  input  logic              role_master,
  input  logic              dir_write,
  input  logic              init_ready,
  input  logic              targ_ready,
  input  logic              parity_in,
  output logic              parity_out,
  output logic              parity_oe,
  output logic              addr_err,
  output logic              data_err
);
  localparam int COVER_W = DATA_W + CBE_W;

  logic      odd_now;
  logic      local_drive;
  chk_kind_e chk_kind;
  logic      par_q;
  logic      oe_q;

  bpu_xor_tree #(.W(COVER_W)) u_tree (
    .vec ({bus_cmd_be, bus_data}),
    .odd (odd_now)
  );

  bpu_role_decode u_dec (
    .addr_phase  (addr_phase),
    .txn_active  (txn_active),
    .role_master (role_master),
    .dir_write   (dir_write),
    .init_ready  (init_ready),
    .targ_ready  (targ_ready),
    .local_drive (local_drive),
    .chk_kind    (chk_kind)
  );

  bpu_par_drive u_drv (
    .clk         (clk),
    .rst         (rst),
    .odd_now     (odd_now),
    .local_drive (local_drive),
    .par_q       (par_q),
    .oe_q        (oe_q)
  );

  // the drive register doubles as the stored calculation for checking
  bpu_par_check u_chk (
    .clk        (clk),
    .rst        (rst),
    .chk_kind   (chk_kind),
    .calc_par   (par_q),
    .par_rx     (parity_in),
    .addr_err_q (addr_err),
    .data_err_q (data_err)
  );

  assign parity_out = par_q;
  assign parity_oe  = oe_q;
endmodule

// File: rtl/bus_parity_unit_checks.sv
module bus_parity_unit_checks #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_data,
  input logic [CBE_W-1:0]  bus_cmd_be,
  input logic              addr_phase,
  input logic              txn_active,
  input logic              role_master,
  input logic              dir_write,
  input logic              init_ready,
  input logic              targ_ready,
  input logic              parity_out,
  input logic              parity_oe,
  input logic              addr_err,
  input logic              data_err
);
  logic arm1, arm2;
  always_ff @(posedge clk) begin
    if (rst) begin
      arm1 <= 1'b0;
      arm2 <= 1'b0;
    end else begin
      arm1 <= 1'b1;
      arm2 <= arm1;
    end
  end

  p_even_r1: assert property (@(posedge clk) disable iff (rst || !arm1)
    (^{$past(bus_cmd_be), $past(bus_data), parity_out}) == 1'b0);

  p_oe_maddr_r2: assert property (@(posedge clk) disable iff (rst)
    (addr_phase && role_master) |=> parity_oe);

  p_oe_mwrite_r3: assert property (@(posedge clk) disable iff (rst)
    (txn_active && !addr_phase && role_master && dir_write) |=> parity_oe);

  p_oe_tread_r4: assert property (@(posedge clk) disable iff (rst)
    (txn_active && !addr_phase && !role_master && !dir_write) |=> parity_oe);

  p_oe_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!addr_phase && !txn_active) |=> !parity_oe);

  p_addr_cause_r6: assert property (@(posedge clk) disable iff (rst || !arm2)
    addr_err |-> $past(addr_phase && !role_master, 2));

  p_data_cause_r7: assert property (@(posedge clk) disable iff (rst || !arm2)
    data_err |-> $past(txn_active && !addr_phase && init_ready && targ_ready
                       && (role_master != dir_write), 2));

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(addr_err && data_err));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!parity_out && !parity_oe && !addr_err && !data_err));
endmodule

bind bus_parity_unit bus_parity_unit_checks #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .bus_data    (bus_data),
  .bus_cmd_be  (bus_cmd_be),
  .addr_phase  (addr_phase),
  .txn_active  (txn_active),
  .role_master (role_master),
  .dir_write   (dir_write),
  .init_ready  (init_ready),
  .targ_ready  (targ_ready),
  .parity_out  (parity_out),
  .parity_oe   (parity_oe),
  .addr_err    (addr_err),
  .data_err    (data_err)
);

// File: tb/bus_parity_unit_tb.sv
`timescale 1ns/1ps
module bus_parity_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_data = '0;
  logic [3:0]  bus_cmd_be = '0;
  logic        addr_phase = 0, txn_active = 0, role_master = 0, dir_write = 0;
  logic        init_ready = 0, targ_ready = 0, parity_in = 0;
  logic        parity_out, parity_oe, addr_err, data_err;

  always #2.5 clk = ~clk;

  bus_parity_unit u_dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .bus_cmd_be(bus_cmd_be),
    .addr_phase(addr_phase), .txn_active(txn_active), .role_master(role_master),
    .dir_write(dir_write), .init_ready(init_ready), .targ_ready(targ_ready),
    .parity_in(parity_in), .parity_out(parity_out), .parity_oe(parity_oe),
    .addr_err(addr_err), .data_err(data_err)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference history entry for one input cycle
  typedef struct packed {
    bit     rst;
    bit     drv;
    bit     achk;
    bit     dchk;
    bit     p;
    bit     pin;
    logic [3:0] tag;
  } hist_t;

  hist_t h1, h2;
  bit last_p = 0;

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic ep, eoe, eae, ede;
    string oe_req;
    ep  = h1.rst ? 1'b0 : h1.p;
    eoe = h1.rst ? 1'b0 : h1.drv;
    eae = !h1.rst && !h2.rst && h2.achk && (h2.p != h1.pin);
    ede = !h1.rst && !h2.rst && h2.dchk && (h2.p != h1.pin);
    case (h1.tag)
      2: oe_req = "R2 oe master address";
      3: oe_req = "R3 oe master write";
      4: oe_req = "R4 oe target read";
      9: oe_req = "R9 oe reset";
      default: oe_req = "R5 oe quiet";
    endcase
    check1(h1.rst ? "R9 parity reset" : "R1 parity value", parity_out, ep);
    check1(oe_req, parity_oe, eoe);
    check1((h1.rst || h2.rst) ? "R9 addr_err reset" :
           (h2.achk ? "R6 addr_err" : "R8 addr_err no check"), addr_err, eae);
    check1((h1.rst || h2.rst) ? "R9 data_err reset" :
           (h2.dchk ? "R7 data_err" : "R8 data_err no check"), data_err, ede);
  endtask

  // one clock: check outputs, then apply the new cycle's inputs.
  // parity_in = parity of the previous cycle's bits XOR flip.
  task automatic step(input bit r, input bit ap, input bit tx, input bit m,
                      input bit w, input bit ir, input bit tr,
                      input logic [31:0] d, input logic [3:0] c, input bit flip);
    hist_t n;
    bit in_data, owns;
    @(negedge clk);
    compare();
    rst = r; addr_phase = ap; txn_active = tx; role_master = m; dir_write = w;
    init_ready = ir; targ_ready = tr; bus_data = d; bus_cmd_be = c;
    parity_in = last_p ^ flip;
    in_data = tx && !ap;
    owns = (m == w);
    n.rst  = r;
    n.p    = ^{d, c};
    n.pin  = last_p ^ flip;
    n.drv  = (ap && m) || (in_data && owns);
    n.achk = ap && !m;
    n.dchk = in_data && ir && tr && !owns;
    if (r) n.tag = 9;
    else if (ap && m) n.tag = 2;
    else if (in_data && m && w) n.tag = 3;
    else if (in_data && !m && !w) n.tag = 4;
    else n.tag = 5;
    last_p = n.p;
    h2 = h1;
    h1 = n;
  endtask

  initial begin
    h1 = '0; h1.rst = 1; h2 = '0; h2.rst = 1;
    // reset (R9)
    repeat (3) step(1, 1, 1, 1, 1, 1, 1, 32'hFFFF_FFFF, 4'hF, 1);
    // idle bus (R5)
    repeat (2) step(0, 0, 0, 0, 0, 0, 0, 32'h0000_0001, 4'h0, 0);
    // master write: address then data with a wait state (R2, R3, R1)
    step(0, 1, 0, 1, 1, 0, 0, 32'h1000_0040, 4'h7, 0);
    step(0, 0, 1, 1, 1, 1, 0, 32'hDEAD_BEEF, 4'h0, 0);
    step(0, 0, 1, 1, 1, 1, 1, 32'hFFFF_FFFF, 4'hF, 1);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
    // target address phase, good parity then bad parity (R6)
    step(0, 1, 0, 0, 0, 0, 0, 32'h8000_0000, 4'h6, 0);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 32'h0000_0100, 4'h6, 0);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
    // target write data: wait state with bad parity (R8), completed bad (R7)
    step(0, 0, 1, 0, 1, 1, 0, 32'h1234_5678, 4'h0, 0);
    step(0, 0, 1, 0, 1, 1, 1, 32'hA5A5_A5A5, 4'h3, 1);
    step(0, 0, 1, 0, 1, 1, 1, 32'h0F0F_0F0F, 4'h1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 1);
    // target read data, local drives (R4), mismatch ignored (R8)
    step(0, 0, 1, 0, 0, 1, 1, 32'h7FFF_FFFF, 4'hF, 0);
    step(0, 0, 1, 0, 0, 1, 1, 32'h0000_0000, 4'h8, 1);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 1);
    // master read completed with bad parity (R7)
    step(0, 0, 1, 1, 0, 1, 1, 32'hCAFE_F00D, 4'h0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 1);
    // address phase precedence over txn_active (R5)
    step(0, 1, 1, 0, 0, 1, 1, 32'h3, 4'h0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 1);
    // reset in the middle of a pending check (R9)
    step(0, 1, 0, 0, 0, 0, 0, 32'h1, 4'h0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 1);
    // random traffic
    for (int k = 0; k < 600; k++) begin
      step(0, ($urandom % 5) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2, $urandom % 2, $urandom, 4'($urandom),
           ($urandom % 4) == 0);
    end
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule